// File: doc/BRIEF.md
# Start/Stop Frame Aligner with Lock

This block sits on the receive side of a serial channel whose line frames carry an 18-bit payload between a start bit (1) and a stop bit (0), for 20 bits per frame. It takes a stream that is already bit-synchronous, one bit for each cycle in which the bit enable is high. It hunts for the frame boundary, removes the two framing bits and hands out the 18-bit payload with a one-cycle valid strobe.

The hunt tests one candidate boundary at a time. Each frame that fails at the current candidate moves the candidate one bit later. The aligner declares lock through an active-low output after several consecutive frames pass at the same candidate. A link partner can shorten the hunt by sending an alignment frame: ten ones followed by ten zeros on the line. Only one boundary position fits that frame, so while unlocked the aligner adopts that position at once. When locked, the aligner tolerates a single damaged frame. Back-to-back damaged frames drop lock and restart the hunt.

Top module: `ssf_aligner`

## Requirements
- R1: While reset is asserted and right after it, `lock_n_o` is 1, `word_vld_o` is 0 and `word_o` is all zeros.
- R2: Line order of a frame is start bit, payload bits 0 through 17, stop bit. A frame passes when its first bit is 1 and its last bit is 0. After reset, the first candidate frame is the first 20 enabled bits.
- R3: The first payload bit received after the start bit appears on `word_o[0]`, and the last one appears on `word_o[17]`.
- R4: While unlocked, `lock_n_o` falls after 4 consecutive passing frames at one candidate boundary. A failing frame clears the count and delays the next candidate boundary by one bit (21 bits to the next frame end).
- R5: While unlocked, whenever the last 20 enabled bits are ten ones followed by ten zeros, that position becomes the frame boundary at once, and lock asserts on the next passing frame. This frame is ignored while locked.
- R6: While locked, one failing frame keeps lock. A second consecutive failing frame raises `lock_n_o`, and the next candidate boundary is one bit later.
- R7: `word_vld_o` is a one-cycle pulse in the cycle after the last bit of each frame that completes while lock holds, including the frame that establishes lock and excluding the frame that drops it. `word_o` changes only with that pulse.
- R8: A cycle with `bit_en_i` low changes no state and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Received line bit |
| word_o | output | 18 | Extracted payload, bit 0 is the earliest received |
| word_vld_o | output | 1 | One-cycle strobe for a new payload word |
| lock_n_o | output | 1 | Low while frame alignment holds |

## Verification
A wrong candidate boundary or a miscounted frame position becomes visible at the ports within one frame. The strobe then lands in the wrong cycle, or the payload comes out shifted, and a per-cycle comparison against a behavioural model exposes it on the next clock. A corrupted pass or fail count changes the cycle in which `lock_n_o` moves, so the checks pin down the frame that locks and the frame that unlocks. The alignment-frame shortcut and the hold-off on a single bad frame each get directed checks, because random traffic rarely reaches them.

// File: rtl/ssf_aligner.sv
module ssf_aligner #(
  parameter int DW          = 18,
  parameter int LOCK_FRAMES = 4,
  parameter int LOSS_FRAMES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en_i,
  input  logic          bit_i,
  output logic [DW-1:0] word_o,
  output logic          word_vld_o,
  output logic          lock_n_o
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(FW) + 1;
  localparam int GW = $clog2(LOCK_FRAMES + 1);
  localparam int BW = $clog2(LOSS_FRAMES + 1);
  localparam logic [FW-1:0] SYNC_PAT = {{(FW/2){1'b0}}, {(FW/2){1'b1}}};

  logic [FW-1:0] sr;
  logic [CW-1:0] cnt;
  logic [GW-1:0] good;
  logic [BW-1:0] bad;
  logic          locked;

  wire [FW-1:0] win        = {bit_i, sr[FW-1:1]};
  wire          frame_done = bit_en_i && (cnt == CW'(FW-1));
  wire          frame_ok   = win[0] && !win[FW-1];
  wire          sync_hit   = bit_en_i && !locked && (win == SYNC_PAT);

  assign lock_n_o = !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; cnt <= '0; good <= '0; bad <= '0;
      locked <= 1'b0; word_vld_o <= 1'b0; word_o <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (bit_en_i) begin
        sr  <= win;
        cnt <= cnt + 1'b1;
      end
      if (sync_hit) begin
        cnt  <= '0;
        good <= GW'(LOCK_FRAMES - 1);
      end else if (frame_done) begin
        cnt <= '0;
        if (!locked) begin
          if (!frame_ok) begin
            good <= '0;
            cnt  <= '1;
          end else if (good == GW'(LOCK_FRAMES - 1)) begin
            locked <= 1'b1; good <= '0; bad <= '0;
            word_vld_o <= 1'b1; word_o <= win[DW:1];
          end else begin
            good <= good + 1'b1;
          end
        end else if (frame_ok) begin
          bad <= '0;
          word_vld_o <= 1'b1; word_o <= win[DW:1];
        end else if (bad == BW'(LOSS_FRAMES - 1)) begin
          locked <= 1'b0; bad <= '0; good <= '0;
          cnt <= '1;
        end else begin
          bad <= bad + 1'b1;
          word_vld_o <= 1'b1; word_o <= win[DW:1];
        end
      end
    end
  end

  // R7
  vld_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> !lock_n_o);
  // R7
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);
  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_o |-> $stable(word_o));
  // R4
  lock_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n_o) |-> $past(frame_done && frame_ok));
  // R6
  lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_n_o) |-> $past(frame_done && !frame_ok));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i |=> ($stable(sr) && $stable(cnt) && !word_vld_o));
endmodule

// File: tb/ssf_aligner_tb_top.sv
module ssf_aligner_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en_i = 1'b0;
  logic bit_i = 1'b0;
  logic [17:0] word_o;
  logic word_vld_o, lock_n_o;

  always #2 clk = ~clk;

  ssf_aligner dut_i (.clk(clk), .rst_n(rst_n), .bit_en_i(bit_en_i), .bit_i(bit_i),
                     .word_o(word_o), .word_vld_o(word_vld_o), .lock_n_o(lock_n_o));

  int checks = 0, fails = 0;
  bit q[$];
  int pos = 0, goods = 0, bads = 0;
  bit mlock = 0;
  logic exp_vld = 0, exp_lock_n = 1;
  logic [17:0] exp_word = '0;
  int vld_seen = 0, stepno = 0, last_vld = -1, gap_bad = 0;
  bit gappy = 0;
  int gap_ctr = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic emit();
    exp_vld = 1;
    for (int i = 0; i < 18; i++) exp_word[i] = q[1+i];
  endtask

  task automatic model(input logic en, input logic b);
    bit ok, sy;
    exp_vld = 0;
    if (!en) return;
    q.push_back(b);
    void'(q.pop_front());
    pos++;
    ok = (q[0] == 1) && (q[19] == 0);
    sy = 1;
    for (int i = 0; i < 20; i++) if (q[i] != (i < 10)) sy = 0;
    if (!mlock && sy) begin
      pos = 0; goods = 3;
    end else if (pos == 20) begin
      pos = 0;
      if (!mlock) begin
        if (ok) begin
          goods++;
          if (goods == 4) begin mlock = 1; goods = 0; bads = 0; emit(); end
        end else begin goods = 0; pos = -1; end
      end else if (ok) begin
        bads = 0; emit();
      end else begin
        bads++;
        if (bads == 2) begin mlock = 0; bads = 0; goods = 0; pos = -1; end
        else emit();
      end
    end
    exp_lock_n = !mlock;
  endtask

  task automatic step(input logic en, input logic b);
    @(negedge clk);
    check("R4/R6 lock_n vs model", 32'(lock_n_o), 32'(exp_lock_n));
    check("R7 strobe vs model", 32'(word_vld_o), 32'(exp_vld));
    check("R2/R3 word vs model", 32'(word_o), 32'(exp_word));
    if (word_vld_o) begin
      vld_seen++;
      if (last_vld >= 0 && !gappy && stepno - last_vld != 20) gap_bad++;
      last_vld = stepno;
    end
    stepno++;
    bit_en_i = en; bit_i = b;
    model(en, b);
  endtask

  task automatic send_bit(input logic b);
    if (gappy) begin
      gap_ctr++;
      if (gap_ctr % 3 == 0) step(1'b0, 1'b1);
    end
    step(1'b1, b);
  endtask

  task automatic send_frame(input logic [17:0] d, input logic st, input logic sp);
    send_bit(st);
    for (int i = 0; i < 18; i++) send_bit(d[i]);
    send_bit(sp);
  endtask

  logic [17:0] lcg = 18'h1D2C3;
  function automatic logic [17:0] nxt(input logic [17:0] x);
    return x * 18'd1103 + 18'd12345;
  endfunction

  initial begin
    for (int i = 0; i < 20; i++) q.push_back(1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 lock_n in reset", 32'(lock_n_o), 32'd1);
    check("R1 strobe in reset", 32'(word_vld_o), 32'd0);
    check("R1 word in reset", 32'(word_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: three frames not enough, fourth locks
    send_frame(18'h00001, 1, 0);
    send_frame(18'h2AAAA, 1, 0);
    send_frame(18'h15555, 1, 0);
    step(0, 0);
    check("R4 no lock after 3 frames", 32'(lock_n_o), 32'd1);
    send_frame(18'h00001, 1, 0);
    step(0, 0);
    check("R4 lock after 4 frames", 32'(lock_n_o), 32'd0);
    check("R3 first payload bit on word bit 0", 32'(word_o), 32'h00001);
    send_frame(18'h20000, 1, 0);
    step(0, 0);
    check("R3 last payload bit on word bit 17", 32'(word_o), 32'h20000);

    // R7: strobe once per frame, 20 cycles apart
    vld_seen = 0; last_vld = -1; gap_bad = 0;
    for (int f = 0; f < 5; f++) begin lcg = nxt(lcg); send_frame(lcg, 1, 0); end
    step(0, 0);
    check("R7 strobes over 5 frames", 32'(vld_seen), 32'd5);
    check("R7 strobe spacing 20", 32'(gap_bad), 32'd0);
    check("R2 payload of last frame", 32'(word_o), 32'(lcg));

    // R8: idle cycles have no effect
    vld_seen = 0;
    for (int i = 0; i < 30; i++) step(0, 1);
    check("R8 no strobe while idle", 32'(vld_seen), 32'd0);
    check("R8 lock held while idle", 32'(lock_n_o), 32'd0);
    check("R8 word held while idle", 32'(word_o), 32'(lcg));

    // R6: single bad frame tolerated, two drop lock
    send_frame(18'h0F0F0, 1, 1);
    send_frame(18'h00333, 1, 0);
    step(0, 0);
    check("R6 one bad frame keeps lock", 32'(lock_n_o), 32'd0);
    send_frame(18'h00333, 0, 0);
    send_frame(18'h00333, 0, 0);
    step(0, 0);
    check("R6 two bad frames drop lock", 32'(lock_n_o), 32'd1);

    // R4: hunt walks back to the true boundary, with enable gaps
    gappy = 1;
    for (int f = 0; f < 40; f++) send_frame(18'h0000F, 1, 0);
    gappy = 0;
    step(0, 0);
    check("R4 relock after hunt", 32'(lock_n_o), 32'd0);
    check("R2 payload after hunt", 32'(word_o), 32'h0000F);

    // R5: alignment frame at an odd offset
    send_frame(18'h0000F, 0, 0);
    send_frame(18'h0000F, 0, 0);
    step(0, 0);
    check("R5 unlocked before alignment frame", 32'(lock_n_o), 32'd1);
    for (int i = 0; i < 7; i++) step(1, 0);
    send_frame(18'h001FF, 1, 0);
    step(0, 0);
    check("R5 no lock on alignment frame itself", 32'(lock_n_o), 32'd1);
    send_frame(18'h12345, 1, 0);
    step(0, 0);
    check("R5 lock on next frame", 32'(lock_n_o), 32'd0);
    check("R5 payload after fast lock", 32'(word_o), 32'h12345);

    // mixed traffic against the model
    for (int f = 0; f < 20; f++) begin lcg = nxt(lcg); send_frame(lcg, 1, (f % 7 == 3)); end
    step(0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule